// File: doc/BRIEF.md
# Expansion Bus Chip-Select Controller

This block takes single read and write requests from an internal bus and carries them out on an external expansion bus. The address space is split into eight chip-select regions. The top address bits pick the region. Each region has its own control word. The control word sets whether the region is enabled, whether writes are allowed, whether the data path is 8 or 16 bits wide, and whether address and data share the data pins. It also sets whether reads are answered with a split acknowledgement, and how a ready line on the upper regions is read. Control words are written and read through a register port that is separate from the data path.

The block decides whether an access is legal before any bus phase begins. An illegal access is answered with an error and never drives a chip select or a strobe. A legal access walks through five ordered phases: address, setup, strobe, hold and recovery. Each phase takes one cycle plus a programmable 2-bit extension. On regions 4 to 7 a device can hold off the strobe phase through its ready line.

Top module: `xbus_cs_ctrl`

## Requirements
- R1: A write on the register port stores into region `cfg_sel` these fields, and `cfg_rdata` returns them for the selected region, with every other bit reading 0:
  - bit 31: enable
  - bit 6: host-port ready mode
  - bit 5: ready polarity (1 = active high)
  - bit 4: multiplexed
  - bit 3: split reads
  - bit 1: write allowed
  - bit 0: 16-bit width
  - bits 17:16, 19:18, 21:20, 23:22 and 25:24: extension counts for the address, setup, strobe, hold and recovery phases.
- R2: After reset, region 0 reads 32'h8000_0000 (enabled, write-protected, 8-bit, no extensions). Every other region reads 0.
- R3: An access to a region whose enable bit is 0 gets `rsp_valid` with `rsp_err`=1 in the cycle after acceptance. It asserts no chip select and no strobe.
- R4: A write to a region whose write-allowed bit is 0 is answered the same way as R3: an error, with no chip select and no strobe. Reads of that region proceed normally.
- R5: The region index is `req_addr[ADDR_W-1 -: 3]`. Only the bit `xb_cs_n[region]` is ever driven low, and only during the setup, strobe and hold phases.
- R6: Phases run in the order address, setup, strobe, hold, recovery. Each phase lasts 1 plus its extension count in cycles. A legal access's `rsp_valid` comes 6 plus the sum of its extensions cycles after acceptance, with `rsp_err`=0.
- R7: `xb_rd_n` (for reads) or `xb_wr_n` (for writes) is low exactly during the strobe phase. The two are never low together.
- R8: In 8-bit mode a read returns {8'h00, `xb_din[7:0]`} and a write drives {8'h00, wdata[7:0]}. In 16-bit mode all 16 bits pass through. Read data is sampled in the last strobe cycle.
- R9: In multiplexed mode `xb_ale` is high for the whole address phase, with `xb_doe`=1 and `xb_dout` = `req_addr[15:0]`. In non-multiplexed mode `xb_ale` stays low.
- R10: A legal read to a region with split reads set produces a one-cycle `rsp_split` pulse in the cycle after acceptance, before `rsp_valid`. Writes and non-split reads never pulse it.
- R11: In regions 4 to 7 with host-port mode set, the strobe phase cannot end while `xb_rdy[region-4]` differs from the polarity bit. All other regions ignore `xb_rdy`.
- R12: `req_ready` is 1 only while no access is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_sel | input | 3 | Region selected on the register port |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word of the selected region |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Block idle, request can be accepted |
| rsp_valid | output | 1 | Completion pulse |
| rsp_err | output | 1 | Completion is an error (valid with rsp_valid) |
| rsp_split | output | 1 | Split acknowledgement pulse |
| rsp_rdata | output | 16 | Read data (valid with rsp_valid) |
| xb_cs_n | output | 8 | Active-low chip selects |
| xb_addr | output | ADDR_W | External address |
| xb_ale | output | 1 | Address latch enable in multiplexed mode |
| xb_rd_n | output | 1 | Active-low read strobe |
| xb_wr_n | output | 1 | Active-low write strobe |
| xb_dout | output | 16 | Data pins, driven side |
| xb_doe | output | 1 | Data pin output enable |
| xb_din | input | 16 | Data pins, sampled side |
| xb_rdy | input | 4 | Ready lines for regions 4 to 7 |

## Verification
The embedded properties watch the external pins on every cycle. They check that at most one chip select is low, that the two strobes never overlap, that a strobe only appears while a chip select is active, and that the address latch enable only comes with driven data pins. They also check that a rejected access leaves the bus quiet, that the split pulse lasts one cycle, and that the strobe phase is held while the selected ready line is inactive. The scenarios cover what needs a known configuration:
- exact latencies for different extension counts
- zero-extended 8-bit data and full 16-bit data
- the multiplexed address value
- the reset control words and read-back masking
- stall lengths under both ready polarities, and a ready line being ignored where host-port mode does not apply.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

    localparam int DATA_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int CFG_W    = 32;
    localparam int EXT_W    = 2;
    localparam int NUM_PH   = 5;

    localparam int BIT_EN    = 31;
    localparam int BIT_HOST  = 6;
    localparam int BIT_POL   = 5;
    localparam int BIT_MUX   = 4;
    localparam int BIT_SPLIT = 3;
    localparam int BIT_WROK  = 1;
    localparam int BIT_WIDE  = 0;
    localparam int EXT_LSB   = 16;

    typedef struct packed {
        logic                             en;
        logic                             host;
        logic                             rdy_pol;
        logic                             mux;
        logic                             split;
        logic                             wr_ok;
        logic                             wide;
        logic [NUM_PH-1:0][EXT_W-1:0]     ext;
    } cs_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4,
        PH_RECOV  = 3'd5
    } phase_e;

    function automatic cs_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        cs_cfg_t c;
        c.en      = w[BIT_EN];
        c.host    = w[BIT_HOST];
        c.rdy_pol = w[BIT_POL];
        c.mux     = w[BIT_MUX];
        c.split   = w[BIT_SPLIT];
        c.wr_ok   = w[BIT_WROK];
        c.wide    = w[BIT_WIDE];
        for (int i = 0; i < NUM_PH; i++) begin
            c.ext[i] = w[EXT_LSB + EXT_W*i +: EXT_W];
        end
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_pack(input cs_cfg_t c);
        logic [CFG_W-1:0] w;
        w            = '0;
        w[BIT_EN]    = c.en;
        w[BIT_HOST]  = c.host;
        w[BIT_POL]   = c.rdy_pol;
        w[BIT_MUX]   = c.mux;
        w[BIT_SPLIT] = c.split;
        w[BIT_WROK]  = c.wr_ok;
        w[BIT_WIDE]  = c.wide;
        for (int i = 0; i < NUM_PH; i++) begin
            w[EXT_LSB + EXT_W*i +: EXT_W] = c.ext[i];
        end
        return w;
    endfunction

    // Region 0 leaves reset enabled but write-protected; the rest are off.
    function automatic cs_cfg_t cfg_reset(input int idx);
        cs_cfg_t c;
        c    = '0;
        c.en = (idx == 0);
        return c;
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_ADDR:   return PH_SETUP;
            PH_SETUP:  return PH_STROBE;
            PH_STROBE: return PH_HOLD;
            PH_HOLD:   return PH_RECOV;
            default:   return PH_IDLE;
        endcase
    endfunction

    function automatic logic [EXT_W-1:0] phase_ext(input cs_cfg_t c, input phase_e p);
        case (p)
            PH_ADDR:   return c.ext[0];
            PH_SETUP:  return c.ext[1];
            PH_STROBE: return c.ext[2];
            PH_HOLD:   return c.ext[3];
            PH_RECOV:  return c.ext[4];
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/xbus_cfg_regs.sv
`timescale 1ns/1ps
module xbus_cfg_regs
    import xbus_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int SEL_W = $clog2(NUM_CS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [SEL_W-1:0]         cfg_sel,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output logic [CFG_W-1:0]         cfg_rdata,
    output cs_cfg_t [NUM_CS-1:0]     cfg_all
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_region
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_all[g] <= cfg_reset(g);
            end else if (cfg_we && (cfg_sel == SEL_W'(g))) begin
                cfg_all[g] <= cfg_unpack(cfg_wdata);
            end
        end
    end

    always_comb begin
        cfg_rdata = cfg_pack(cfg_all[cfg_sel]);
    end

endmodule

// File: rtl/xbus_decode.sv
`timescale 1ns/1ps
module xbus_decode
    import xbus_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int NUM_CS   = 8,
    parameter int RDY_BASE = 4,
    localparam int SEL_W   = $clog2(NUM_CS)
) (
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_write,
    input  cs_cfg_t [NUM_CS-1:0]     cfg_all,
    output logic [SEL_W-1:0]         region,
    output cs_cfg_t                  sel_cfg,
    output logic                     acc_err,
    output logic                     rdy_use
);

    always_comb begin
        region  = req_addr[ADDR_W-1 -: SEL_W];
        sel_cfg = cfg_all[region];
        // Disabled region, or a write into a protected one.
        acc_err = !sel_cfg.en || (req_write && !sel_cfg.wr_ok);
        // Host-port ready handling exists only on the upper regions.
        rdy_use = sel_cfg.host && (int'(region) >= RDY_BASE);
    end

endmodule

// File: rtl/xbus_phase_fsm.sv
`timescale 1ns/1ps
module xbus_phase_fsm
    import xbus_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int NUM_CS   = 8,
    parameter int RDY_BASE = 4,
    localparam int SEL_W   = $clog2(NUM_CS),
    localparam int NUM_RDY = NUM_CS - RDY_BASE,
    localparam int RDY_W   = (NUM_RDY > 1) ? $clog2(NUM_RDY) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [SEL_W-1:0]     region,
    input  cs_cfg_t              sel_cfg,
    input  logic                 acc_err,
    input  logic                 rdy_use,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic                 rsp_split,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [NUM_CS-1:0]    xb_cs_n,
    output logic [ADDR_W-1:0]    xb_addr,
    output logic                 xb_ale,
    output logic                 xb_rd_n,
    output logic                 xb_wr_n,
    output logic [DATA_W-1:0]    xb_dout,
    output logic                 xb_doe,
    input  logic [DATA_W-1:0]    xb_din,
    input  logic [NUM_RDY-1:0]   xb_rdy
);

    phase_e              ph;
    logic [EXT_W-1:0]    cnt;
    cs_cfg_t             cur_cfg;
    logic [SEL_W-1:0]    cur_region;
    logic                cur_write;
    logic [ADDR_W-1:0]   cur_addr;
    logic [DATA_W-1:0]   cur_wdata;
    logic                cur_rdy_use;

    logic [RDY_W-1:0]    rdy_idx;
    logic                rdy_ok;
    logic                in_cs_window;
    logic                in_addr_mux;
    logic [DATA_W-1:0]   wr_lane;
    logic [DATA_W-1:0]   rd_lane;

    always_comb begin
        rdy_idx      = RDY_W'(cur_region - SEL_W'(RDY_BASE));
        rdy_ok       = !cur_rdy_use || (xb_rdy[rdy_idx] == cur_cfg.rdy_pol);
        in_cs_window = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
        in_addr_mux  = (ph == PH_ADDR) && cur_cfg.mux;
        wr_lane      = cur_cfg.wide ? cur_wdata
                                    : {{(DATA_W-BYTE_W){1'b0}}, cur_wdata[BYTE_W-1:0]};
        rd_lane      = cur_cfg.wide ? xb_din
                                    : {{(DATA_W-BYTE_W){1'b0}}, xb_din[BYTE_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph          <= PH_IDLE;
            cnt         <= '0;
            cur_cfg     <= '0;
            cur_region  <= '0;
            cur_write   <= 1'b0;
            cur_addr    <= '0;
            cur_wdata   <= '0;
            cur_rdy_use <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_err     <= 1'b0;
            rsp_split   <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_split <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur_cfg     <= sel_cfg;
                        cur_region  <= region;
                        cur_write   <= req_write;
                        cur_addr    <= req_addr;
                        cur_wdata   <= req_wdata;
                        cur_rdy_use <= rdy_use;
                        rsp_rdata   <= '0;
                        if (acc_err) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                        end else begin
                            ph        <= PH_ADDR;
                            cnt       <= sel_cfg.ext[0];
                            rsp_err   <= 1'b0;
                            rsp_split <= !req_write && sel_cfg.split;
                        end
                    end
                end
                default: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if ((ph != PH_STROBE) || rdy_ok) begin
                        if ((ph == PH_STROBE) && !cur_write) begin
                            rsp_rdata <= rd_lane;
                        end
                        if (ph == PH_RECOV) begin
                            ph        <= PH_IDLE;
                            rsp_valid <= 1'b1;
                        end else begin
                            ph  <= next_phase(ph);
                            cnt <= phase_ext(cur_cfg, next_phase(ph));
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        req_ready = (ph == PH_IDLE);
        xb_addr   = (ph != PH_IDLE) ? cur_addr : '0;
        xb_cs_n   = in_cs_window ? ~(NUM_CS'(1) << cur_region) : '1;
        xb_ale    = in_addr_mux;
        xb_rd_n   = !((ph == PH_STROBE) && !cur_write);
        xb_wr_n   = !((ph == PH_STROBE) && cur_write);
        xb_doe    = in_addr_mux || (cur_write && in_cs_window);
        if (in_addr_mux) begin
            xb_dout = cur_addr[DATA_W-1:0];
        end else if (cur_write && in_cs_window) begin
            xb_dout = wr_lane;
        end else begin
            xb_dout = '0;
        end
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~xb_cs_n)); // R5

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!xb_rd_n && !xb_wr_n)); // R7

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        (!xb_rd_n || !xb_wr_n) |-> !(&xb_cs_n)); // R7

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && acc_err) |=> (rsp_valid && rsp_err && (&xb_cs_n) && xb_rd_n && xb_wr_n)); // R3

    AST_SPLIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_split |=> !rsp_split); // R10

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((ph == PH_STROBE) && (cnt == '0) && !rdy_ok) |=> ((ph == PH_STROBE) && !rsp_valid)); // R11

endmodule

// File: rtl/xbus_cs_ctrl.sv
`timescale 1ns/1ps
module xbus_cs_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int NUM_CS   = 8,
    parameter int RDY_BASE = 4,
    localparam int SEL_W   = $clog2(NUM_CS),
    localparam int NUM_RDY = NUM_CS - RDY_BASE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic                 rsp_split,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [NUM_CS-1:0]    xb_cs_n,
    output logic [ADDR_W-1:0]    xb_addr,
    output logic                 xb_ale,
    output logic                 xb_rd_n,
    output logic                 xb_wr_n,
    output logic [DATA_W-1:0]    xb_dout,
    output logic                 xb_doe,
    input  logic [DATA_W-1:0]    xb_din,
    input  logic [NUM_RDY-1:0]   xb_rdy
);

    cs_cfg_t [NUM_CS-1:0]  cfg_all;
    logic [SEL_W-1:0]      region;
    cs_cfg_t               sel_cfg;
    logic                  acc_err;
    logic                  rdy_use;

    xbus_cfg_regs #(
        .NUM_CS    (NUM_CS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_all   (cfg_all)
    );

    xbus_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_CS    (NUM_CS),
        .RDY_BASE  (RDY_BASE)
    ) u_decode (
        .req_addr  (req_addr),
        .req_write (req_write),
        .cfg_all   (cfg_all),
        .region    (region),
        .sel_cfg   (sel_cfg),
        .acc_err   (acc_err),
        .rdy_use   (rdy_use)
    );

    xbus_phase_fsm #(
        .ADDR_W    (ADDR_W),
        .NUM_CS    (NUM_CS),
        .RDY_BASE  (RDY_BASE)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .region    (region),
        .sel_cfg   (sel_cfg),
        .acc_err   (acc_err),
        .rdy_use   (rdy_use),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_split (rsp_split),
        .rsp_rdata (rsp_rdata),
        .xb_cs_n   (xb_cs_n),
        .xb_addr   (xb_addr),
        .xb_ale    (xb_ale),
        .xb_rd_n   (xb_rd_n),
        .xb_wr_n   (xb_wr_n),
        .xb_dout   (xb_dout),
        .xb_doe    (xb_doe),
        .xb_din    (xb_din),
        .xb_rdy    (xb_rdy)
    );

    AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        xb_ale |-> (xb_doe && (&xb_cs_n))); // R9

    AST_SPLIT_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        rsp_split |-> !rsp_valid); // R10

endmodule

// File: tb/xbus_cs_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_cs_ctrl_bench;
    import xbus_pkg::*;

    localparam int ADDR_W   = 24;
    localparam int NUM_CS   = 8;
    localparam int RDY_BASE = 4;
    localparam int NUM_RDY  = NUM_CS - RDY_BASE;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 cfg_we = 1'b0;
    logic [2:0]           cfg_sel = '0;
    logic [31:0]          cfg_wdata = '0;
    logic [31:0]          cfg_rdata;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic [15:0]          req_wdata = '0;
    logic                 req_ready, rsp_valid, rsp_err, rsp_split;
    logic [15:0]          rsp_rdata;
    logic [NUM_CS-1:0]    xb_cs_n;
    logic [ADDR_W-1:0]    xb_addr;
    logic                 xb_ale, xb_rd_n, xb_wr_n, xb_doe;
    logic [15:0]          xb_dout, xb_din;
    logic [NUM_RDY-1:0]   xb_rdy = '0;

    always #2.5 clk = ~clk;

    // Simple device model: returns the inverted low address bits.
    assign xb_din = ~xb_addr[15:0];

    xbus_cs_ctrl #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .RDY_BASE(RDY_BASE)) u_xbus_cs_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_split(rsp_split),
        .rsp_rdata(rsp_rdata), .xb_cs_n(xb_cs_n), .xb_addr(xb_addr), .xb_ale(xb_ale),
        .xb_rd_n(xb_rd_n), .xb_wr_n(xb_wr_n), .xb_dout(xb_dout), .xb_doe(xb_doe),
        .xb_din(xb_din), .xb_rdy(xb_rdy)
    );

    typedef struct {
        bit          err;
        bit          split;
        logic [15:0] data;
        int          lat;
        string       tag;
    } sb_item_t;

    sb_item_t     sb[$];
    int           errors = 0;
    int           checks = 0;
    int           lat = 0, strobe_cnt = 0, cs_cnt = 0, ale_cnt = 0, done_cnt = 0;
    logic [15:0]  wr_seen = '0, ale_val = '0;
    logic [7:0]   cs_or = '0;
    bit           split_seen = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input bit en, input bit host, input bit pol, input bit mux,
                                           input bit split, input bit wr, input bit wide,
                                           input int e1, input int e2, input int e3,
                                           input int e4, input int e5);
        logic [31:0] w;
        w = '0;
        w[31] = en; w[6] = host; w[5] = pol; w[4] = mux; w[3] = split; w[1] = wr; w[0] = wide;
        w[17:16] = 2'(e1); w[19:18] = 2'(e2); w[21:20] = 2'(e3);
        w[23:22] = 2'(e4); w[25:24] = 2'(e5);
        return w;
    endfunction

    // Monitor: observes the pins and pops the scoreboard on every completion.
    always @(negedge clk) begin
        if (!rst) begin
            sb_item_t it;
            lat++;
            if (!xb_rd_n || !xb_wr_n) strobe_cnt++;
            if (!xb_wr_n) wr_seen = xb_dout;
            if (!(&xb_cs_n)) begin cs_cnt++; cs_or = cs_or | ~xb_cs_n; end
            if (xb_ale) begin ale_cnt++; ale_val = xb_dout; end
            if (rsp_split) split_seen = 1'b1;
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R6 unexpected response", 32'(rsp_valid), 32'd0);
                end else begin
                    it = sb.pop_front();
                    chk(rsp_err == it.err, {it.tag, " err"}, 32'(rsp_err), 32'(it.err));
                    chk(split_seen == it.split, {it.tag, " R10 split"}, 32'(split_seen), 32'(it.split));
                    if (!it.err && !it.split) begin
                        chk(rsp_rdata == it.data, {it.tag, " data"}, 32'(rsp_rdata), 32'(it.data));
                    end else if (it.split) begin
                        chk(rsp_rdata == it.data, {it.tag, " split data"}, 32'(rsp_rdata), 32'(it.data));
                    end
                    if (it.lat >= 0) chk(lat == it.lat, {it.tag, " latency"}, 32'(lat), 32'(it.lat));
                end
                done_cnt++;
            end
        end
    end

    task automatic cfg_write(input int sel, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input int sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_sel = 3'(sel);
        #1;
        chk(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    // Driver: issues one access, pushes the expected result, waits for completion.
    task automatic run(input bit wr, input logic [ADDR_W-1:0] a, input logic [15:0] wd,
                       input bit e_err, input bit e_split, input logic [15:0] e_data,
                       input int e_lat, input string tag);
        sb_item_t it;
        int start;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        it.err = e_err; it.split = e_split; it.data = e_data; it.lat = e_lat; it.tag = tag;
        sb.push_back(it);
        start = done_cnt;
        @(posedge clk);
        lat = 0; strobe_cnt = 0; cs_cnt = 0; ale_cnt = 0; cs_or = '0;
        split_seen = 1'b0; wr_seen = '0; ale_val = '0;
        @(negedge clk);
        req_valid = 1'b0;
        if (!e_err) chk(req_ready == 1'b0, "R12 busy during access", 32'(req_ready), 32'd0);
        #1;
        while (done_cnt == start) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic release_after(input int n, input int idx, input logic v);
        do begin
            @(negedge clk);
            #1;
        end while (strobe_cnt < n);
        xb_rdy[idx] = v;
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R2: reset values and idle bus
        cfg_check(0, 32'h8000_0000, "R2 region0 reset word");
        cfg_check(3, 32'h0000_0000, "R2 region3 reset word");
        chk(req_ready == 1'b1, "R12 idle ready", 32'(req_ready), 32'd1);
        chk(&xb_cs_n, "R5 idle chip selects", 32'(xb_cs_n), 32'hFF);

        // R1: read-back keeps only defined fields
        cfg_write(2, 32'hFFFF_FFFF);
        cfg_check(2, 32'h83FF_007B, "R1 read-back mask");

        // R4: region 0 is write-protected, reads proceed (R8 8-bit read, R6 base latency)
        run(1'b1, 24'h0000A5, 16'h1234, 1'b1, 1'b0, 16'h0, 1, "R4 write-protected");
        chk(cs_cnt == 0 && strobe_cnt == 0, "R4 no bus activity", 32'(cs_cnt + strobe_cnt), 32'd0);
        run(1'b0, 24'h0000A5, 16'h0, 1'b0, 1'b0, 16'h005A, 6, "R8 8-bit read region0");
        chk(strobe_cnt == 1, "R7 one strobe cycle", 32'(strobe_cnt), 32'd1);
        chk(cs_or == 8'h01, "R5 region0 select", 32'(cs_or), 32'h01);

        // R3: disabled region
        run(1'b0, 24'h200010, 16'h0, 1'b1, 1'b0, 16'h0, 1, "R3 disabled region");
        chk(cs_cnt == 0 && strobe_cnt == 0, "R3 no bus activity", 32'(cs_cnt + strobe_cnt), 32'd0);

        // R6: extensions 1,2,3,0,1 on a 16-bit non-multiplexed region
        cfg_write(2, mk_cfg(1, 0, 0, 0, 0, 1, 1, 1, 2, 3, 0, 1));
        run(1'b1, 24'h441234, 16'hCAFE, 1'b0, 1'b0, 16'h0, 13, "R6 extended write");
        chk(strobe_cnt == 4, "R7 strobe length", 32'(strobe_cnt), 32'd4);
        chk(cs_cnt == 8, "R5 cs window length", 32'(cs_cnt), 32'd8);
        chk(cs_or == 8'h04, "R5 region2 select", 32'(cs_or), 32'h04);
        chk(wr_seen == 16'hCAFE, "R8 16-bit write lane", 32'(wr_seen), 32'hCAFE);
        chk(ale_cnt == 0, "R9 no ale in non-mux", 32'(ale_cnt), 32'd0);
        run(1'b0, 24'h441234, 16'h0, 1'b0, 1'b0, 16'hEDCB, 13, "R8 16-bit read");

        // R9, R10: multiplexed 8-bit split region with address extension 2
        cfg_write(3, mk_cfg(1, 0, 0, 1, 1, 1, 0, 2, 0, 0, 0, 0));
        run(1'b0, 24'h600F0F, 16'h0, 1'b0, 1'b1, 16'h00F0, 8, "R10 split read");
        chk(ale_cnt == 3, "R9 ale length", 32'(ale_cnt), 32'd3);
        chk(ale_val == 16'h0F0F, "R9 multiplexed address", 32'(ale_val), 32'h0F0F);
        run(1'b1, 24'h600F0F, 16'hBEEF, 1'b0, 1'b0, 16'h0, 8, "R10 write no split");
        chk(wr_seen == 16'h00EF, "R8 8-bit write lane", 32'(wr_seen), 32'h00EF);

        // R11: active-high ready on region 5, held low until 4 strobe cycles
        cfg_write(5, mk_cfg(1, 1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0));
        xb_rdy = 4'b0000;
        strobe_cnt = 0;
        fork
            run(1'b0, 24'hA00010, 16'h0, 1'b0, 1'b0, 16'hFFEF, -1, "R11 high-ready read");
            release_after(4, 1, 1'b1);
        join
        chk(strobe_cnt == 4, "R11 stall active-high", 32'(strobe_cnt), 32'd4);
        chk(cs_or == 8'h20, "R5 region5 select", 32'(cs_or), 32'h20);

        // R11: active-low ready on region 6
        cfg_write(6, mk_cfg(1, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0));
        xb_rdy = 4'b1111;
        strobe_cnt = 0;
        fork
            run(1'b0, 24'hC00020, 16'h0, 1'b0, 1'b0, 16'hFFDF, -1, "R11 low-ready read");
            release_after(3, 2, 1'b0);
        join
        chk(strobe_cnt == 3, "R11 stall active-low", 32'(strobe_cnt), 32'd3);

        // R11: ready ignored without host mode and below region 4
        cfg_write(7, mk_cfg(1, 0, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0));
        xb_rdy = 4'b0000;
        run(1'b0, 24'hE00001, 16'h0, 1'b0, 1'b0, 16'hFFFE, 6, "R11 ignored region7");
        chk(strobe_cnt == 1, "R11 no stall region7", 32'(strobe_cnt), 32'd1);
        cfg_write(2, mk_cfg(1, 1, 1, 0, 0, 1, 1, 0, 0, 3, 0, 0));
        run(1'b0, 24'h440002, 16'h0, 1'b0, 1'b0, 16'hFFFD, 9, "R11 ignored region2");
        chk(strobe_cnt == 4, "R11 no stall region2", 32'(strobe_cnt), 32'd4);

        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R6 scoreboard drained", 32'(sb.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule